// File: doc/BRIEF.md
# Serializing Instruction Barrier Unit

This block sits in the in-order part of a processor front end and decides, for every fetched instruction, whether it may flow on at once or must wait for the machine to go quiet. Each instruction arrives with a sequence number and a set of attribute flags that an earlier decoder has produced. Most instructions pass straight through with one cycle of latency. An instruction that has to serialize before it executes is taken out of the stream and parked, and the unit raises a hold indication. The instruction is released again only after the reorder buffer and the fetch buffer behind the unit have both drained.

An instruction that has to serialize after it executes is let through, but the unit remembers this with a single carry bit. It then treats the next instruction as one that must serialize before it. A squash from the back end throws away a parked instruction. Three counters record how many serializing instructions were seen, how many temporary serializations occurred, and how many cycles were spent waiting for the drain.

Top module: `sbar_unit`

## Requirements
- R1: An accepted instruction with none of the serializing, register-access or store-conditional flags set, while the carry bit is clear, appears on the output one cycle later with its sequence number, before-mark and handled bit unchanged. No counter moves.
- R2: A register-access instruction not yet handled is parked instead of emitted: out_valid stays 0 and hold is 1 from the cycle after acceptance. The same holds for a serialize-before instruction not yet handled that also carries the serializing flag (or arrives with the carry bit set).
- R3: A parked instruction without the temporary flag adds 1 to cnt_serial and is later re-emitted with out_handled 1. A parked instruction with the temporary flag adds 1 to cnt_temp instead, leaves cnt_serial unchanged, and is re-emitted with out_handled 0.
- R4: A store-conditional instruction not yet handled, or a serialize-after instruction not yet handled that carries the serializing flag, is emitted at once with out_handled 1. It adds 1 to cnt_serial and sets the carry bit.
- R5: While the carry bit is set, the next accepted instruction is treated as serialize-before, and the carry bit is then clear. If that instruction is not yet handled it is parked. If it is already handled it passes with out_ser_before 1. The instruction after it passes with out_ser_before 0.
- R6: The before-mark and after-mark take effect only together with the serializing flag, the carry bit, or (for the before case) register access. An instruction that is already handled never parks and moves no counter.
- R7: The unit leaves the waiting state only at a clock edge where rob_empty and buf_empty are both 1. One of them alone keeps it waiting.
- R8: One cycle after the drain edge, the parked instruction is emitted with its own sequence number and out_ser_before 0. In that cycle release_pulse is 1 and hold is 0. release_pulse lasts exactly one cycle.
- R9: cnt_stall rises by 1 at every clock edge at which the unit is in the waiting state, including the drain edge and a squash edge.
- R10: Instructions presented while hold is 1 are ignored: they are neither emitted nor counted.
- R11: squash_valid drops a parked instruction. The next cycle has hold 0, and the instruction is never released. squash_seq must be older, that is numerically smaller, than the parked sequence number. An instruction presented in the squash cycle is ignored.
- R12: After reset, hold, out_valid and release_pulse are 0, all three counters are 0, and the carry bit is clear, so the first plain instruction passes with out_ser_before 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_seq | input | SEQ_W | Sequence number of the instruction |
| in_serializing | input | 1 | Instruction is serializing |
| in_reg_access | input | 1 | Instruction accesses a privileged register |
| in_store_cond | input | 1 | Instruction is a store-conditional |
| in_ser_before | input | 1 | Serialize-before mark |
| in_ser_after | input | 1 | Serialize-after mark |
| in_temp | input | 1 | Serialization is temporary |
| in_handled | input | 1 | Serialization already handled |
| rob_empty | input | 1 | Reorder buffer is empty |
| buf_empty | input | 1 | Fetch buffer downstream is empty |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash sequence number |
| out_valid | output | 1 | Instruction emitted |
| out_seq | output | SEQ_W | Emitted sequence number |
| out_ser_before | output | 1 | Emitted before-mark |
| out_handled | output | 1 | Emitted handled bit |
| hold | output | 1 | Unit holds a barrier; new input is ignored |
| release_pulse | output | 1 | Parked barrier emitted this cycle |
| cnt_serial | output | CNT_W | Serializing instruction count |
| cnt_temp | output | CNT_W | Temporary serialization count |
| cnt_stall | output | CNT_W | Cycles spent waiting for drain |

## Verification
Several properties are checked on every cycle. The unit stays in the waiting state until both drain signals are high. A release carries a cleared before-mark and always follows the completion state. Any non-release output traces back to a running-state acceptance. The carry bit clears after it is used. cnt_stall steps by one per waiting edge. A squash respects sequence order. Plain instructions come out one cycle later with their own sequence number. The bench scenarios show which attribute combinations park, pass or set the carry. They also show the handled bit after a temporary or permanent barrier, that inputs offered while held are ignored, and that a squashed barrier never comes back.

// File: rtl/sbar_pkg.sv
package sbar_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BLOCK = 2'd1,
    ST_DONE  = 2'd2
  } sbar_state_e;

  typedef struct packed {
    logic serializing;
    logic reg_access;
    logic store_cond;
    logic ser_before;
    logic ser_after;
    logic temp;
    logic handled;
  } sbar_attr_t;

  localparam int unsigned SBAR_NUM_CNT = 3;
  localparam int unsigned CNT_SERIAL   = 0;
  localparam int unsigned CNT_TEMP     = 1;
  localparam int unsigned CNT_STALL    = 2;

endpackage

// File: rtl/sbar_classify.sv
module sbar_classify
  import sbar_pkg::*;
(
  input  sbar_attr_t attr,
  input  logic       carry,
  output logic       take_hold,
  output logic       mark_after,
  output logic       eff_before,
  output logic       handled_out,
  output logic       cnt_as_serial,
  output logic       cnt_as_temp
);

  logic gate;

  always_comb begin
    gate          = carry | attr.serializing | attr.reg_access | attr.store_cond;
    eff_before    = attr.ser_before | carry;
    take_hold     = gate & (attr.reg_access | eff_before) & ~attr.handled;
    mark_after    = gate & ~take_hold & (attr.store_cond | attr.ser_after) & ~attr.handled;
    handled_out   = attr.handled | mark_after;
    cnt_as_serial = (take_hold & ~attr.temp) | mark_after;
    cnt_as_temp   = take_hold & attr.temp;
  end

endmodule

// File: rtl/sbar_ctrl.sv
module sbar_ctrl
  import sbar_pkg::*;
#(
  parameter int unsigned SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic             in_temp,
  input  logic             take_hold,
  input  logic             mark_after,
  input  logic             eff_before,
  input  logic             handled_in,
  input  logic             rob_empty,
  input  logic             buf_empty,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             carry,
  output logic             accept,
  output logic             stalled,
  output logic             hold,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  output logic             out_ser_before,
  output logic             out_handled,
  output logic             release_pulse
);

  sbar_state_e      state;
  logic [SEQ_W-1:0] bar_seq;
  logic             bar_handled;
  logic             drained;

  assign drained = rob_empty & buf_empty;
  assign hold    = (state != ST_RUN);
  assign stalled = (state == ST_BLOCK);
  assign accept  = in_valid & ~squash_valid & (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_RUN;
      carry          <= 1'b0;
      bar_seq        <= '0;
      bar_handled    <= 1'b0;
      out_valid      <= 1'b0;
      out_seq        <= '0;
      out_ser_before <= 1'b0;
      out_handled    <= 1'b0;
      release_pulse  <= 1'b0;
    end else begin
      out_valid     <= 1'b0;
      release_pulse <= 1'b0;
      if (squash_valid) begin
        state <= ST_RUN;
      end else begin
        unique case (state)
          ST_RUN: begin
            if (in_valid) begin
              carry <= mark_after;
              if (take_hold) begin
                bar_seq     <= in_seq;
                bar_handled <= ~in_temp;
                state       <= ST_BLOCK;
              end else begin
                out_valid      <= 1'b1;
                out_seq        <= in_seq;
                out_ser_before <= eff_before;
                out_handled    <= handled_in;
              end
            end
          end
          ST_BLOCK: begin
            if (drained) state <= ST_DONE;
          end
          ST_DONE: begin
            out_valid      <= 1'b1;
            out_seq        <= bar_seq;
            out_ser_before <= 1'b0;
            out_handled    <= bar_handled;
            release_pulse  <= 1'b1;
            state          <= ST_RUN;
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  // R7
  drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLOCK) && !drained && !squash_valid |=> (state == ST_BLOCK));

  // R8
  release_clean_chk: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> out_valid && !out_ser_before && !hold);

  // R8
  release_origin_chk: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> $past(state) == ST_DONE);

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !release_pulse |-> $past(state) == ST_RUN && $past(in_valid));

  // R5
  carry_once_chk: assert property (@(posedge clk) disable iff (rst)
    carry && accept |=> !carry);

  // R11
  squash_order_chk: assert property (@(posedge clk) disable iff (rst)
    squash_valid && hold |-> bar_seq > squash_seq);

endmodule

// File: rtl/sbar_counters.sv
module sbar_counters #(
  parameter int unsigned NUM = 3,
  parameter int unsigned W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   inc,
  output logic [NUM*W-1:0] cnt_flat
);

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [W-1:0] value;
    always_ff @(posedge clk) begin
      if (rst)         value <= '0;
      else if (inc[i]) value <= value + 1'b1;
    end
    assign cnt_flat[i*W +: W] = value;
  end

endmodule

// File: rtl/sbar_unit.sv
module sbar_unit
  import sbar_pkg::*;
#(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic             in_serializing,
  input  logic             in_reg_access,
  input  logic             in_store_cond,
  input  logic             in_ser_before,
  input  logic             in_ser_after,
  input  logic             in_temp,
  input  logic             in_handled,
  input  logic             rob_empty,
  input  logic             buf_empty,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  output logic             out_ser_before,
  output logic             out_handled,
  output logic             hold,
  output logic             release_pulse,
  output logic [CNT_W-1:0] cnt_serial,
  output logic [CNT_W-1:0] cnt_temp,
  output logic [CNT_W-1:0] cnt_stall
);

  localparam int unsigned NCNT = SBAR_NUM_CNT;

  sbar_attr_t attr;
  logic carry, accept, stalled;
  logic take_hold, mark_after, eff_before, handled_out;
  logic cnt_as_serial, cnt_as_temp;
  logic [NCNT-1:0]       inc;
  logic [NCNT*CNT_W-1:0] cnt_flat;

  assign attr = '{serializing: in_serializing, reg_access: in_reg_access,
                  store_cond: in_store_cond, ser_before: in_ser_before,
                  ser_after: in_ser_after, temp: in_temp, handled: in_handled};

  sbar_classify u_cls (
    .attr          (attr),
    .carry         (carry),
    .take_hold     (take_hold),
    .mark_after    (mark_after),
    .eff_before    (eff_before),
    .handled_out   (handled_out),
    .cnt_as_serial (cnt_as_serial),
    .cnt_as_temp   (cnt_as_temp)
  );

  sbar_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_seq         (in_seq),
    .in_temp        (in_temp),
    .take_hold      (take_hold),
    .mark_after     (mark_after),
    .eff_before     (eff_before),
    .handled_in     (handled_out),
    .rob_empty      (rob_empty),
    .buf_empty      (buf_empty),
    .squash_valid   (squash_valid),
    .squash_seq     (squash_seq),
    .carry          (carry),
    .accept         (accept),
    .stalled        (stalled),
    .hold           (hold),
    .out_valid      (out_valid),
    .out_seq        (out_seq),
    .out_ser_before (out_ser_before),
    .out_handled    (out_handled),
    .release_pulse  (release_pulse)
  );

  always_comb begin
    inc             = '0;
    inc[CNT_SERIAL] = accept & cnt_as_serial;
    inc[CNT_TEMP]   = accept & cnt_as_temp;
    inc[CNT_STALL]  = stalled;
  end

  sbar_counters #(.NUM(NCNT), .W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (inc),
    .cnt_flat (cnt_flat)
  );

  assign cnt_serial = cnt_flat[CNT_SERIAL*CNT_W +: CNT_W];
  assign cnt_temp   = cnt_flat[CNT_TEMP*CNT_W +: CNT_W];
  assign cnt_stall  = cnt_flat[CNT_STALL*CNT_W +: CNT_W];

  // R9
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    stalled |=> cnt_stall == $past(cnt_stall) + 1'b1);

  // R2
  park_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    accept && take_hold |=> hold && !out_valid);

  // R1
  pass_seq_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !take_hold |=> out_valid && out_seq == $past(in_seq));

endmodule

// File: tb/sbar_unit_test.sv
`timescale 1ns/1ps
module sbar_unit_test;

  localparam int SEQ_W = 8;
  localparam int CNT_W = 16;

  localparam logic [6:0] A_SER = 7'b1000000;
  localparam logic [6:0] A_REG = 7'b0100000;
  localparam logic [6:0] A_SC  = 7'b0010000;
  localparam logic [6:0] A_SB  = 7'b0001000;
  localparam logic [6:0] A_SA  = 7'b0000100;
  localparam logic [6:0] A_TMP = 7'b0000010;
  localparam logic [6:0] A_HND = 7'b0000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic [6:0] attr = '0;
  logic rob_empty = 1'b0, buf_empty = 1'b0;
  logic squash_valid = 1'b0;
  logic [SEQ_W-1:0] squash_seq = '0;
  logic out_valid, out_ser_before, out_handled, hold, release_pulse;
  logic [SEQ_W-1:0] out_seq;
  logic [CNT_W-1:0] cnt_serial, cnt_temp, cnt_stall;

  int checks = 0;
  int errors = 0;
  int b_ser, b_tmp, b_stl;

  always #10 clk = ~clk;

  sbar_unit #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_seq(in_seq),
    .in_serializing(attr[6]), .in_reg_access(attr[5]), .in_store_cond(attr[4]),
    .in_ser_before(attr[3]), .in_ser_after(attr[2]), .in_temp(attr[1]),
    .in_handled(attr[0]), .rob_empty(rob_empty), .buf_empty(buf_empty),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .out_valid(out_valid), .out_seq(out_seq), .out_ser_before(out_ser_before),
    .out_handled(out_handled), .hold(hold), .release_pulse(release_pulse),
    .cnt_serial(cnt_serial), .cnt_temp(cnt_temp), .cnt_stall(cnt_stall)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic present(input logic [6:0] a, input int seq);
    in_valid = 1'b1;
    attr     = a;
    in_seq   = SEQ_W'(seq);
    step();
    in_valid = 1'b0;
    attr     = '0;
  endtask

  task automatic snap();
    b_ser = int'(cnt_serial);
    b_tmp = int'(cnt_temp);
    b_stl = int'(cnt_stall);
  endtask

  task automatic drain_release(input string req, input int seq, input int handled);
    rob_empty = 1'b1;
    buf_empty = 1'b1;
    step();
    check(req, "hold at completion", int'(hold), 1);
    check(req, "no output at completion", int'(out_valid), 0);
    step();
    rob_empty = 1'b0;
    buf_empty = 1'b0;
    check("R8", "release pulse", int'(release_pulse), 1);
    check("R8", "release valid", int'(out_valid), 1);
    check("R8", "release seq", int'(out_seq), seq);
    check("R8", "release before-mark", int'(out_ser_before), 0);
    check("R8", "hold after release", int'(hold), 0);
    check(req, "release handled", int'(out_handled), handled);
    step();
    check("R8", "pulse one cycle", int'(release_pulse), 0);
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R12", "hold", int'(hold), 0);
    check("R12", "out_valid", int'(out_valid), 0);
    check("R12", "release", int'(release_pulse), 0);
    check("R12", "cnt_serial", int'(cnt_serial), 0);
    check("R12", "cnt_temp", int'(cnt_temp), 0);
    check("R12", "cnt_stall", int'(cnt_stall), 0);
    present(7'b0, 1);
    check("R12", "first out before-mark", int'(out_ser_before), 0);
    check("R12", "first out valid", int'(out_valid), 1);
  endtask

  task automatic t_plain();
    snap();
    present(7'b0, 10);
    check("R1", "valid", int'(out_valid), 1);
    check("R1", "seq", int'(out_seq), 10);
    check("R1", "before-mark", int'(out_ser_before), 0);
    check("R1", "handled", int'(out_handled), 0);
    check("R1", "hold", int'(hold), 0);
    step();
    check("R1", "valid one cycle", int'(out_valid), 0);
    present(A_SB, 11);
    check("R6", "before-mark alone passes", int'(out_valid), 1);
    check("R6", "before-mark kept", int'(out_ser_before), 1);
    check("R6", "no hold", int'(hold), 0);
    present(A_SA, 14);
    check("R6", "after-mark alone no handled", int'(out_handled), 0);
    check("R1", "counters still", int'(cnt_serial) + int'(cnt_temp), b_ser + b_tmp);
  endtask

  task automatic t_handled();
    snap();
    present(A_SER | A_SB | A_HND, 12);
    check("R6", "handled before passes", int'(out_valid), 1);
    check("R6", "handled before no hold", int'(hold), 0);
    check("R6", "handled bit", int'(out_handled), 1);
    present(A_REG | A_HND, 13);
    check("R6", "handled reg passes", int'(out_valid), 1);
    check("R6", "handled reg no hold", int'(hold), 0);
    check("R6", "no count", int'(cnt_serial), b_ser);
  endtask

  task automatic t_after();
    snap();
    present(A_SC, 20);
    check("R4", "sc passes", int'(out_valid), 1);
    check("R4", "sc seq", int'(out_seq), 20);
    check("R4", "sc handled", int'(out_handled), 1);
    check("R4", "sc count", int'(cnt_serial), b_ser + 1);
    present(7'b0, 21);
    check("R5", "next parked", int'(hold), 1);
    check("R5", "next not emitted", int'(out_valid), 0);
    check("R5", "next counted", int'(cnt_serial), b_ser + 2);
    drain_release("R5", 21, 1);
    present(7'b0, 22);
    check("R5", "carry cleared", int'(out_ser_before), 0);
    check("R5", "carry cleared no hold", int'(hold), 0);
    snap();
    present(A_SER | A_SA, 23);
    check("R4", "after-mark handled", int'(out_handled), 1);
    check("R4", "after-mark count", int'(cnt_serial), b_ser + 1);
    present(A_HND, 24);
    check("R5", "handled carried passes", int'(out_valid), 1);
    check("R5", "carried before-mark", int'(out_ser_before), 1);
    check("R5", "carried no hold", int'(hold), 0);
    present(7'b0, 25);
    check("R5", "following before-mark", int'(out_ser_before), 0);
  endtask

  task automatic t_barrier();
    snap();
    present(A_REG, 40);
    check("R2", "hold", int'(hold), 1);
    check("R2", "not emitted", int'(out_valid), 0);
    check("R3", "serial count", int'(cnt_serial), b_ser + 1);
    in_valid = 1'b1;
    in_seq   = 8'd41;
    attr     = A_SC;
    repeat (3) begin
      step();
      check("R10", "ignored input", int'(out_valid), 0);
    end
    rob_empty = 1'b1;
    repeat (2) begin
      step();
      check("R7", "rob alone keeps hold", int'(hold), 1);
    end
    rob_empty = 1'b0;
    buf_empty = 1'b1;
    step();
    check("R7", "buf alone keeps hold", int'(hold), 1);
    in_valid = 1'b0;
    attr     = '0;
    check("R10", "ignored not counted", int'(cnt_serial), b_ser + 1);
    check("R9", "stall count", int'(cnt_stall), b_stl + 6);
    drain_release("R3", 40, 1);
    check("R9", "stall final", int'(cnt_stall), b_stl + 7);
  endtask

  task automatic t_temp();
    snap();
    present(A_SER | A_SB | A_TMP, 50);
    check("R3", "temp hold", int'(hold), 1);
    check("R3", "temp count", int'(cnt_temp), b_tmp + 1);
    check("R3", "serial unchanged", int'(cnt_serial), b_ser);
    drain_release("R3", 50, 0);
    check("R9", "temp stall", int'(cnt_stall), b_stl + 1);
  endtask

  task automatic t_squash();
    snap();
    present(A_REG, 60);
    check("R11", "parked", int'(hold), 1);
    step();
    step();
    squash_valid = 1'b1;
    squash_seq   = 8'd55;
    in_valid     = 1'b1;
    in_seq       = 8'd61;
    step();
    squash_valid = 1'b0;
    in_valid     = 1'b0;
    check("R11", "hold dropped", int'(hold), 0);
    check("R11", "no output", int'(out_valid), 0);
    check("R11", "no release", int'(release_pulse), 0);
    check("R9", "squash stall", int'(cnt_stall), b_stl + 3);
    rob_empty = 1'b1;
    buf_empty = 1'b1;
    repeat (3) begin
      step();
      check("R11", "never released", int'(release_pulse) + int'(out_valid), 0);
    end
    rob_empty = 1'b0;
    buf_empty = 1'b0;
    present(7'b0, 62);
    check("R11", "running again", int'(out_valid), 1);
    check("R11", "running seq", int'(out_seq), 62);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_handled();
    t_after();
    t_barrier();
    t_temp();
    t_squash();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule